// File: doc/BRIEF.md
# Multi-Function Pin Router

This block decides, for each of ten shared device pins, which internal function owns the pin and whether the pin is driven. Three inputs choose among the pin maps, and the first one that is active wins. A hardware-mode strap selects a fixed pin map used when no software control is present. If the strap is low, an enable for the secondary audio port gives four pins to that port. If neither applies, each pin falls back to its software choice. On three pins that choice is made by a select bit: S/PDIF receiver input or general-purpose output.

Two pins do not follow a select bit. The first pin gives its transmit bit clock to a general-purpose output only when the transmit clock tree and the ADC clock tree both run from the master clock. The second pin stops being the dedicated ADC master-clock input only when no clock tree uses that input.

The router drives internal sources out to the pins and copies pin values into named internal nets. For each pin it also produces an output enable. The pads, the register file and the clock generators are outside the block. Every output is registered once, so a configuration change appears at the ports one clock after it is applied.

Top module: `mfp_router`

## Requirements
- R1: While `rst` is high, all `pin_out`, `pin_oe` and routed input nets are 0. Once reset is released, each output shows the configuration and the sources sampled at the previous rising clock edge.
- R2: With `hw_strap`=1 the map does not depend on `sec_en`, `gpo_pick` or any clock select. Pin 1 (index 0) is the transmit bit clock. Pin 2 is the ADC master-clock input. Pins 3..6 feed `hw_route[0..3]`. Pin 7 feeds `hw_pwrdn`. Pin 8 drives `subfr_src`, pin 9 drives `blk_src` and pin 10 drives `gpo_val[9]`.
- R3: With `hw_strap`=0 and `sec_en`=1, the secondary port owns four pins. Pin 6 is its bit clock, pin 7 its word clock, pin 8 its data input (`sec_din`) and pin 9 drives `sec_dout_src`. All other pins follow the per-pin selection.
- R4: In the per-pin selection, pins 3, 4 and 5 drive `gpo_val` when `gpo_pick[0..2]` is 1. When the bit is 0 the pin is S/PDIF receive input `spdif_rx[0..2]`. Pins 6..10 drive their `gpo_val` bit.
- R5: Clock select codes are 0 = master clock, 1 = dedicated ADC master clock, 2 and 3 = PLL clocks. Outside hardware mode, pin 1 drives `gpo_val[0]` only when `adc_csel` and `tx_csel` are both 0. In every other case pin 1 is the transmit bit clock.
- R6: Outside hardware mode, pin 2 drives `gpo_val[1]` only when none of `adc_csel`, `tx_csel` and `sec_csel` equals 1. Otherwise pin 2 is the ADC master-clock input and feeds `adc_mclk_in`.
- R7: A pin whose function is an input has `pin_oe`=0. Any pin with `pin_oe`=0 has `pin_out`=0.
- R8: A routed input net equals the pin value only while its function is mapped to a pin as an input. Otherwise the net is 0.
- R9: The transmit bit clock pin is an output of `tx_bclk_src` when `tx_master`=1. When `tx_master`=0 it is an input to `tx_bclk_in`. The secondary bit clock and word clock pins follow `sec_master` in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_strap | input | 1 | Hardware-mode strap |
| sec_en | input | 1 | Secondary audio port enable |
| gpo_pick | input | 3 | Per-pin select for pins 3..5, 1 = general-purpose output |
| adc_csel | input | 2 | ADC clock source select |
| tx_csel | input | 2 | Transmit port clock source select |
| sec_csel | input | 2 | Secondary port clock source select |
| tx_master | input | 1 | Transmit port generates its bit clock |
| sec_master | input | 1 | Secondary port generates its clocks |
| gpo_val | input | 10 | General-purpose output values, one per pin |
| tx_bclk_src | input | 1 | Internal transmit bit clock |
| sec_bclk_src | input | 1 | Internal secondary bit clock |
| sec_lrclk_src | input | 1 | Internal secondary word clock |
| sec_dout_src | input | 1 | Secondary port serial data out |
| subfr_src | input | 1 | S/PDIF sub-frame indicator |
| blk_src | input | 1 | S/PDIF 192-frame block start flag |
| pin_in | input | 10 | Values read from the pads |
| pin_out | output | 10 | Values driven to the pads |
| pin_oe | output | 10 | Pad output enables |
| tx_bclk_in | output | 1 | Transmit bit clock from pin (slave) |
| adc_mclk_in | output | 1 | ADC master clock from pin |
| spdif_rx | output | 3 | Extra S/PDIF receiver inputs |
| hw_route | output | 4 | Hardware-mode routing configuration |
| hw_pwrdn | output | 1 | Hardware-mode power-down |
| sec_bclk_in | output | 1 | Secondary bit clock from pin (slave) |
| sec_lrclk_in | output | 1 | Secondary word clock from pin (slave) |
| sec_din | output | 1 | Secondary port serial data in |

## Verification
Several priorities can decide the same pin in the same cycle. One case is the pin 1 and pin 2 clock-select overrides together with the secondary enable or the hardware strap. Another is two of these switching together, for example the strap and a clock select changing on the same edge. The bench covers these by sweeping every combination of strap, secondary enable, all three clock selects and both master flags, and it applies the vectors back to back, so the mode and the selects change on the same edge. Each registered result is compared against a pin map that the bench builds from the priority order. The hardware map must win over the overrides, and the overrides must win over the secondary enable on pins 1 and 2.

// File: rtl/mfp_pkg.sv
`timescale 1ns/1ps
package mfp_pkg;
  localparam int CSEL_W = 2;
  localparam logic [CSEL_W-1:0] CSEL_MCLK    = 2'd0;
  localparam logic [CSEL_W-1:0] CSEL_ADCMCLK = 2'd1;
  localparam int N_ALT = 3;  // pins carrying an optional S/PDIF input
  localparam int N_CFG = 4;  // hardware routing strap inputs

  typedef enum logic [4:0] {
    FN_GPO, FN_TXBCLK, FN_ADCMCLK,
    FN_SPD0, FN_SPD1, FN_SPD2,
    FN_CFG0, FN_CFG1, FN_CFG2, FN_CFG3,
    FN_PWRDN, FN_SUBFR, FN_BLK,
    FN_SBCLK, FN_SLRCLK, FN_SDIN, FN_SDOUT
  } fn_e;
endpackage

// File: rtl/mfp_func_sel.sv
`timescale 1ns/1ps
module mfp_func_sel
  import mfp_pkg::*;
#(
  parameter int NPIN = 10
) (
  input  logic              hw_strap,
  input  logic              sec_en,
  input  logic [N_ALT-1:0]  gpo_pick,
  input  logic [CSEL_W-1:0] adc_csel,
  input  logic [CSEL_W-1:0] tx_csel,
  input  logic [CSEL_W-1:0] sec_csel,
  output fn_e               fn_o [NPIN]
);
  logic p1_free, p2_free;

  always_comb begin
    // pin 1 is released only if nothing needs its bit clock
    p1_free = (adc_csel == CSEL_MCLK) && (tx_csel == CSEL_MCLK);
    // pin 2 is released only if no tree uses the dedicated ADC clock
    p2_free = (adc_csel != CSEL_ADCMCLK) && (tx_csel != CSEL_ADCMCLK) &&
              (sec_csel != CSEL_ADCMCLK);
    for (int i = 0; i < NPIN; i++) begin
      case (i)
        0: fn_o[i] = (!hw_strap && p1_free) ? FN_GPO : FN_TXBCLK;
        1: fn_o[i] = (!hw_strap && p2_free) ? FN_GPO : FN_ADCMCLK;
        2: fn_o[i] = hw_strap ? FN_CFG0 : (gpo_pick[0] ? FN_GPO : FN_SPD0);
        3: fn_o[i] = hw_strap ? FN_CFG1 : (gpo_pick[1] ? FN_GPO : FN_SPD1);
        4: fn_o[i] = hw_strap ? FN_CFG2 : (gpo_pick[2] ? FN_GPO : FN_SPD2);
        5: fn_o[i] = hw_strap ? FN_CFG3  : (sec_en ? FN_SBCLK  : FN_GPO);
        6: fn_o[i] = hw_strap ? FN_PWRDN : (sec_en ? FN_SLRCLK : FN_GPO);
        7: fn_o[i] = hw_strap ? FN_SUBFR : (sec_en ? FN_SDIN   : FN_GPO);
        8: fn_o[i] = hw_strap ? FN_BLK   : (sec_en ? FN_SDOUT  : FN_GPO);
        default: fn_o[i] = FN_GPO;
      endcase
    end
  end
endmodule

// File: rtl/mfp_pin_drive.sv
`timescale 1ns/1ps
module mfp_pin_drive
  import mfp_pkg::*;
(
  input  fn_e  fn_i,
  input  logic gpo_bit,
  input  logic tx_master,
  input  logic sec_master,
  input  logic tx_bclk_src,
  input  logic sec_bclk_src,
  input  logic sec_lrclk_src,
  input  logic sec_dout_src,
  input  logic subfr_src,
  input  logic blk_src,
  output logic drv_o,
  output logic oe_o
);
  always_comb begin
    drv_o = 1'b0;
    oe_o  = 1'b0;
    case (fn_i)
      FN_GPO:    begin oe_o = 1'b1;       drv_o = gpo_bit; end
      FN_TXBCLK: begin oe_o = tx_master;  drv_o = tx_master & tx_bclk_src; end
      FN_SBCLK:  begin oe_o = sec_master; drv_o = sec_master & sec_bclk_src; end
      FN_SLRCLK: begin oe_o = sec_master; drv_o = sec_master & sec_lrclk_src; end
      FN_SDOUT:  begin oe_o = 1'b1;       drv_o = sec_dout_src; end
      FN_SUBFR:  begin oe_o = 1'b1;       drv_o = subfr_src; end
      FN_BLK:    begin oe_o = 1'b1;       drv_o = blk_src; end
      default:   begin oe_o = 1'b0;       drv_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/mfp_in_route.sv
`timescale 1ns/1ps
module mfp_in_route
  import mfp_pkg::*;
#(
  parameter int NPIN = 10
) (
  input  fn_e              fn_i [NPIN],
  input  logic [NPIN-1:0]  pin_in,
  input  logic             tx_master,
  input  logic             sec_master,
  output logic             tx_bclk_in,
  output logic             adc_mclk_in,
  output logic [N_ALT-1:0] spdif_rx,
  output logic [N_CFG-1:0] hw_route,
  output logic             hw_pwrdn,
  output logic             sec_bclk_in,
  output logic             sec_lrclk_in,
  output logic             sec_din
);
  always_comb begin
    tx_bclk_in   = 1'b0;
    adc_mclk_in  = 1'b0;
    spdif_rx     = '0;
    hw_route     = '0;
    hw_pwrdn     = 1'b0;
    sec_bclk_in  = 1'b0;
    sec_lrclk_in = 1'b0;
    sec_din      = 1'b0;
    for (int i = 0; i < NPIN; i++) begin
      case (fn_i[i])
        FN_TXBCLK:  tx_bclk_in   |= pin_in[i] & ~tx_master;
        FN_ADCMCLK: adc_mclk_in  |= pin_in[i];
        FN_SPD0:    spdif_rx[0]  |= pin_in[i];
        FN_SPD1:    spdif_rx[1]  |= pin_in[i];
        FN_SPD2:    spdif_rx[2]  |= pin_in[i];
        FN_CFG0:    hw_route[0]  |= pin_in[i];
        FN_CFG1:    hw_route[1]  |= pin_in[i];
        FN_CFG2:    hw_route[2]  |= pin_in[i];
        FN_CFG3:    hw_route[3]  |= pin_in[i];
        FN_PWRDN:   hw_pwrdn     |= pin_in[i];
        FN_SBCLK:   sec_bclk_in  |= pin_in[i] & ~sec_master;
        FN_SLRCLK:  sec_lrclk_in |= pin_in[i] & ~sec_master;
        FN_SDIN:    sec_din      |= pin_in[i];
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/mfp_router.sv
`timescale 1ns/1ps
module mfp_router
  import mfp_pkg::*;
#(
  parameter int NPIN = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_strap,
  input  logic              sec_en,
  input  logic [N_ALT-1:0]  gpo_pick,
  input  logic [CSEL_W-1:0] adc_csel,
  input  logic [CSEL_W-1:0] tx_csel,
  input  logic [CSEL_W-1:0] sec_csel,
  input  logic              tx_master,
  input  logic              sec_master,
  input  logic [NPIN-1:0]   gpo_val,
  input  logic              tx_bclk_src,
  input  logic              sec_bclk_src,
  input  logic              sec_lrclk_src,
  input  logic              sec_dout_src,
  input  logic              subfr_src,
  input  logic              blk_src,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic              tx_bclk_in,
  output logic              adc_mclk_in,
  output logic [N_ALT-1:0]  spdif_rx,
  output logic [N_CFG-1:0]  hw_route,
  output logic              hw_pwrdn,
  output logic              sec_bclk_in,
  output logic              sec_lrclk_in,
  output logic              sec_din
);
  fn_e               fn_w [NPIN];
  logic [NPIN-1:0]   drv_w, oe_w;
  logic              txb_w, adcm_w, pwd_w, sbc_w, slr_w, sdi_w;
  logic [N_ALT-1:0]  spd_w;
  logic [N_CFG-1:0]  cfg_w;

  mfp_func_sel #(.NPIN(NPIN)) u_sel (
    .hw_strap (hw_strap), .sec_en (sec_en), .gpo_pick (gpo_pick),
    .adc_csel (adc_csel), .tx_csel (tx_csel), .sec_csel (sec_csel),
    .fn_o     (fn_w)
  );

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    mfp_pin_drive u_drv (
      .fn_i (fn_w[g]), .gpo_bit (gpo_val[g]),
      .tx_master (tx_master), .sec_master (sec_master),
      .tx_bclk_src (tx_bclk_src), .sec_bclk_src (sec_bclk_src),
      .sec_lrclk_src (sec_lrclk_src), .sec_dout_src (sec_dout_src),
      .subfr_src (subfr_src), .blk_src (blk_src),
      .drv_o (drv_w[g]), .oe_o (oe_w[g])
    );
  end

  mfp_in_route #(.NPIN(NPIN)) u_in (
    .fn_i (fn_w), .pin_in (pin_in),
    .tx_master (tx_master), .sec_master (sec_master),
    .tx_bclk_in (txb_w), .adc_mclk_in (adcm_w), .spdif_rx (spd_w),
    .hw_route (cfg_w), .hw_pwrdn (pwd_w), .sec_bclk_in (sbc_w),
    .sec_lrclk_in (slr_w), .sec_din (sdi_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0; pin_oe <= '0;
      tx_bclk_in <= 1'b0; adc_mclk_in <= 1'b0; spdif_rx <= '0;
      hw_route <= '0; hw_pwrdn <= 1'b0; sec_bclk_in <= 1'b0;
      sec_lrclk_in <= 1'b0; sec_din <= 1'b0;
    end else begin
      pin_out <= drv_w; pin_oe <= oe_w;
      tx_bclk_in <= txb_w; adc_mclk_in <= adcm_w; spdif_rx <= spd_w;
      hw_route <= cfg_w; hw_pwrdn <= pwd_w; sec_bclk_in <= sbc_w;
      sec_lrclk_in <= slr_w; sec_din <= sdi_w;
    end
  end

  // hardware map: pins 3..7 are inputs and never driven
  assert_hw_inputs_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(hw_strap) && !$past(rst)) |-> (pin_oe[6:2] == 5'b0));

  // secondary port data out owns pin 9
  assert_sec_dout_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(!hw_strap && sec_en && !rst)) |->
    (pin_oe[8] && (pin_out[8] == $past(sec_dout_src))));

  // pin 1 released to its general-purpose output
  assert_pin1_gpo_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && !hw_strap && adc_csel == CSEL_MCLK && tx_csel == CSEL_MCLK)) |->
    (pin_oe[0] && (pin_out[0] == $past(gpo_val[0]))));

  // pin 2 held as ADC master-clock input
  assert_pin2_input_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && (hw_strap || adc_csel == CSEL_ADCMCLK ||
      tx_csel == CSEL_ADCMCLK || sec_csel == CSEL_ADCMCLK))) |->
    (!pin_oe[1] && (adc_mclk_in == $past(pin_in[1]))));

  // an undriven pin carries no value
  assert_undriven_low_R7: assert property (@(posedge clk) disable iff (rst)
    ((pin_out & ~pin_oe) == '0));

  // hardware-only nets idle outside hardware mode
  assert_hw_nets_idle_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && !hw_strap)) |-> ((hw_route == '0) && !hw_pwrdn));
endmodule

// File: tb/mfp_router_tb.sv
`timescale 1ns/1ps
module mfp_router_tb_top;
  typedef struct packed {
    logic [9:0]  out;
    logic [9:0]  oe;
    logic [12:0] nets;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic       hw_strap = 0, sec_en = 0, tx_master = 0, sec_master = 0;
  logic [2:0] gpo_pick = 0;
  logic [1:0] adc_csel = 0, tx_csel = 0, sec_csel = 0;
  logic [9:0] gpo_val = 0, pin_in = 0;
  logic tx_bclk_src = 0, sec_bclk_src = 0, sec_lrclk_src = 0;
  logic sec_dout_src = 0, subfr_src = 0, blk_src = 0;
  logic [9:0] pin_out, pin_oe;
  logic tx_bclk_in, adc_mclk_in, hw_pwrdn, sec_bclk_in, sec_lrclk_in, sec_din;
  logic [2:0] spdif_rx;
  logic [3:0] hw_route;

  mfp_router dut_i (
    .clk (clk), .rst (rst), .hw_strap (hw_strap), .sec_en (sec_en),
    .gpo_pick (gpo_pick), .adc_csel (adc_csel), .tx_csel (tx_csel),
    .sec_csel (sec_csel), .tx_master (tx_master), .sec_master (sec_master),
    .gpo_val (gpo_val), .tx_bclk_src (tx_bclk_src), .sec_bclk_src (sec_bclk_src),
    .sec_lrclk_src (sec_lrclk_src), .sec_dout_src (sec_dout_src),
    .subfr_src (subfr_src), .blk_src (blk_src), .pin_in (pin_in),
    .pin_out (pin_out), .pin_oe (pin_oe), .tx_bclk_in (tx_bclk_in),
    .adc_mclk_in (adc_mclk_in), .spdif_rx (spdif_rx), .hw_route (hw_route),
    .hw_pwrdn (hw_pwrdn), .sec_bclk_in (sec_bclk_in),
    .sec_lrclk_in (sec_lrclk_in), .sec_din (sec_din)
  );

  int checks = 0, fails = 0;
  exp_t  expq[$];
  string tagq[$];
  int unsigned seed = 32'h1234_5678;

  function automatic exp_t got_now();
    exp_t g;
    g.out = pin_out; g.oe = pin_oe;
    g.nets = {tx_bclk_in, adc_mclk_in, spdif_rx, hw_route, hw_pwrdn,
              sec_bclk_in, sec_lrclk_in, sec_din};
    return g;
  endfunction

  // expected pin map built from the priority rules
  // codes: 0 gpo,1 txbclk,2 adcmclk,3-5 spdif,6-9 cfg,10 pwrdn,
  //        11 subframe,12 block,13 sec bclk,14 sec lrclk,15 sec din,16 sec dout
  function automatic exp_t model(logic h, logic s, logic [2:0] gp,
      logic [1:0] a, logic [1:0] t, logic [1:0] c, logic tm, logic sm,
      logic [9:0] gv, logic [9:0] pi, logic [5:0] src);
    int k[10];
    exp_t e;
    logic txi = 0, adci = 0, pwd = 0, sbi = 0, sli = 0, sdi = 0;
    logic [2:0] spd = 0;
    logic [3:0] cfg = 0;
    e = '0;
    k[0] = (!h && a == 2'd0 && t == 2'd0) ? 0 : 1;                      // R5
    k[1] = (!h && a != 2'd1 && t != 2'd1 && c != 2'd1) ? 0 : 2;         // R6
    for (int j = 0; j < 3; j++) k[2+j] = h ? 6 + j : (gp[j] ? 0 : 3 + j); // R4
    k[5] = h ? 9  : (s ? 13 : 0);
    k[6] = h ? 10 : (s ? 14 : 0);
    k[7] = h ? 11 : (s ? 15 : 0);
    k[8] = h ? 12 : (s ? 16 : 0);
    k[9] = 0;
    for (int p = 0; p < 10; p++) begin
      case (k[p])
        0:  begin e.oe[p] = 1; e.out[p] = gv[p]; end
        1:  if (tm) begin e.oe[p] = 1; e.out[p] = src[5]; end else txi = pi[p];
        2:  adci = pi[p];
        3, 4, 5: spd[k[p]-3] = pi[p];
        6, 7, 8, 9: cfg[k[p]-6] = pi[p];
        10: pwd = pi[p];
        11: begin e.oe[p] = 1; e.out[p] = src[1]; end
        12: begin e.oe[p] = 1; e.out[p] = src[0]; end
        13: if (sm) begin e.oe[p] = 1; e.out[p] = src[4]; end else sbi = pi[p];
        14: if (sm) begin e.oe[p] = 1; e.out[p] = src[3]; end else sli = pi[p];
        15: sdi = pi[p];
        default: begin e.oe[p] = 1; e.out[p] = src[2]; end
      endcase
    end
    e.nets = {txi, adci, spd, cfg, pwd, sbi, sli, sdi};
    return e;
  endfunction

  // driver: applies one configuration and queues its expected result
  task automatic drive(input logic h, input logic s, input logic [2:0] gp,
      input logic [1:0] a, input logic [1:0] t, input logic [1:0] c,
      input logic tm, input logic sm, input logic [9:0] gv,
      input logic [9:0] pi, input logic [5:0] src, input string tag);
    @(negedge clk);
    hw_strap = h; sec_en = s; gpo_pick = gp; adc_csel = a; tx_csel = t;
    sec_csel = c; tx_master = tm; sec_master = sm; gpo_val = gv; pin_in = pi;
    {tx_bclk_src, sec_bclk_src, sec_lrclk_src, sec_dout_src, subfr_src, blk_src} = src;
    expq.push_back(model(h, s, gp, a, t, c, tm, sm, gv, pi, src));
    tagq.push_back(tag);
  endtask

  // monitor: result of a vector appears after the next rising edge
  always @(posedge clk) begin
    #5;
    if (expq.size() != 0) begin
      exp_t e, g;
      string tg;
      e = expq.pop_front();
      tg = tagq.pop_front();
      g = got_now();
      checks++;
      if (g !== e) begin
        fails++;
        $display("FAIL %s: got out=%h oe=%h nets=%h expected out=%h oe=%h nets=%h",
                 tg, g.out, g.oe, g.nets, e.out, e.oe, e.nets);
      end
    end
  end

  function automatic int unsigned nxt(input int unsigned v);
    return v * 32'd1664525 + 32'd1013904223;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R1: busy configuration applied while reset is held
    hw_strap = 1; sec_en = 1; tx_master = 1; sec_master = 1; gpo_val = '1;
    pin_in = '1; subfr_src = 1; blk_src = 1; tx_bclk_src = 1;
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (got_now() !== '0) begin
      fails++;
      $display("FAIL R1: got %h expected 0", got_now());
    end
    @(negedge clk);
    rst = 0;

    // R5: pin 1 becomes GPO only with both selects on master clock
    drive(0, 0, 3'b111, 2'd0, 2'd0, 2'd2, 1, 0, 10'h001, 10'h000, 6'h3f, "R5");
    drive(0, 0, 3'b111, 2'd0, 2'd2, 2'd2, 1, 0, 10'h000, 10'h000, 6'h20, "R5");
    drive(0, 0, 3'b111, 2'd3, 2'd0, 2'd0, 0, 0, 10'h001, 10'h001, 6'h20, "R5");
    // R6: pin 2 released only if no select uses the dedicated ADC clock
    drive(0, 0, 3'b000, 2'd2, 2'd3, 2'd0, 0, 0, 10'h002, 10'h002, 6'h00, "R6");
    drive(0, 1, 3'b000, 2'd2, 2'd3, 2'd1, 0, 0, 10'h002, 10'h002, 6'h00, "R6");
    // R2: hardware map wins over secondary enable and overrides
    drive(1, 1, 3'b111, 2'd0, 2'd0, 2'd0, 0, 1, 10'h3ff, 10'h07c, 6'h03, "R2");
    // R9: bit clock directions
    drive(0, 1, 3'b000, 2'd1, 2'd1, 2'd1, 0, 0, 10'h000, 10'h061, 6'h3f, "R9");
    drive(0, 1, 3'b000, 2'd1, 2'd1, 2'd1, 1, 1, 10'h000, 10'h061, 6'h3f, "R9");
    // R7 and R8: all pins inputs where possible, pads high
    drive(1, 0, 3'b000, 2'd1, 2'd1, 2'd1, 0, 0, 10'h000, 10'h3ff, 6'h00, "R7");
    drive(0, 0, 3'b000, 2'd1, 2'd1, 2'd1, 0, 0, 10'h000, 10'h3ff, 6'h00, "R8");

    // sweep of every mode, select and direction combination
    for (int m = 0; m < 1024; m++) begin
      logic [9:0] gv, pi;
      logic [5:0] src;
      logic [2:0] gp;
      string tag;
      seed = nxt(seed); gv = seed[21:12];
      seed = nxt(seed); pi = seed[23:14];
      seed = nxt(seed); src = seed[19:14]; gp = seed[26:24];
      tag = m[9] ? "R2" : (m[8] ? "R3" : "R4");
      drive(m[9], m[8], gp, m[7:6], m[5:4], m[3:2], m[1], m[0], gv, pi, src, tag);
    end

    repeat (4) @(posedge clk);
    #8;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule